// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a CPU 24 general-purpose I/O lines. The lines form two 8-bit ports (A and B) and one 8-bit port C. Port C is split into an upper half (bits 7..4) that belongs with port A and a lower half (bits 3..0) that belongs with port B. Port A, port B and each half of port C can be set to input or output on its own. A control register holds these settings. The CPU can read the control register back, and it can set or clear any one port C bit with a single command.

The CPU bus is synchronous to `clk`. It has active-low chip select, read and write strobes, a 2-bit register select, separate write-data and read-data buses, and a read-data enable that replaces a tri-state pin. Each port has a pin input, a latched output value and a per-bit output enable. The output enable is high when that bit is configured as an output.

Top module: `ppi_port_ctrl`

## Requirements
- R1: While `rst` is high, and after it, the control word reads back as 0x9B and every port is an input. After reset every output enable is 0 and every output latch is 0.
- R2: State changes only on a clock edge where `cs_n` and `wr_n` are both low. If either strobe is high, the latches and the control word keep their values.
- R3: `dout_en` is high exactly when `cs_n` and `rd_n` are both low. While `dout_en` is low, `dout` is 0.
- R4: The register select maps as follows: `addr` 0 is port A, 1 is port B, 2 is port C and 3 is the control register. A data write to port A, B or C loads all 8 bits of that port's output latch, whatever the port's direction.
- R5: A control write with bit 7 = 1 is a direction word. Bit 4 sets the direction of port A, bit 3 of port C upper, bit 1 of port B and bit 0 of port C lower. A value of 1 means input. An output-enable bit is 1 only when its port or half is an output.
- R6: A direction word clears the latches of ports A, B and C to 0 on the same clock edge.
- R7: Reading the control register returns bit 7 = 1, bits 6, 5 and 2 = 0, and the four direction bits in the positions given in R5.
- R8: A control write with bit 7 = 0 sets port C bit `din[3:1]` to `din[0]`. The other port C bits and the control word stay unchanged.
- R9: Reading a port or half configured as output returns its latch. Reading one configured as input returns its pin value. Port C is decided separately for each half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from the CPU |
| dout | output | 8 | Read data to the CPU |
| dout_en | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enable per bit |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enable per bit |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enable per bit |

## Verification
The assertions assume that the CPU never asserts `rd_n` and `wr_n` in the same cycle. They also assume that a write strobe lasts exactly one clock, so a single direction word or bit command produces a single write event. The stimulus keeps to this: every bus access is a one-cycle pulse of one strobe, launched on the falling clock edge, and every strobe is released before the next access starts. Pin inputs are changed only while no read is in progress.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PPI_DW  = 8;
  localparam int PPI_HW  = PPI_DW / 2;
  localparam int PPI_SW  = $clog2(PPI_DW);

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } sel_e;

  // direction flags, 1 = input
  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_t;

  localparam dir_t DIR_ALL_IN = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

  function automatic dir_t mode_dirs(input logic [PPI_DW-1:0] w);
    dir_t d;
    d.a_in  = w[4];
    d.cu_in = w[3];
    d.b_in  = w[1];
    d.cl_in = w[0];
    return d;
  endfunction

  function automatic logic [PPI_DW-1:0] ctrl_image(input dir_t d);
    return {1'b1, 2'b00, d.a_in, d.cu_in, 1'b0, d.b_in, d.cl_in};
  endfunction

  // pin where the mask marks input, latch elsewhere
  function automatic logic [PPI_DW-1:0] mix_read(input logic [PPI_DW-1:0] latch,
                                                 input logic [PPI_DW-1:0] pin,
                                                 input logic [PPI_DW-1:0] in_mask);
    return (pin & in_mask) | (latch & ~in_mask);
  endfunction

  function automatic logic [PPI_DW-1:0] bit_onehot(input logic [PPI_SW-1:0] idx);
    return {{(PPI_DW-1){1'b0}}, 1'b1} << idx;
  endfunction
endpackage

// File: rtl/ppi_bus_decode.sv
module ppi_bus_decode
  import ppi_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic       cmd_kind,
  output logic       wr_a,
  output logic       wr_b,
  output logic       wr_c,
  output logic       mode_wr,
  output logic       bsr_wr,
  output logic       rd_en
);
  logic wr_any;
  sel_e sel;

  assign sel    = sel_e'(addr);
  assign wr_any = ~cs_n & ~wr_n;
  assign rd_en  = ~cs_n & ~rd_n;

  assign wr_a    = wr_any && (sel == SEL_A);
  assign wr_b    = wr_any && (sel == SEL_B);
  assign wr_c    = wr_any && (sel == SEL_C);
  assign mode_wr = wr_any && (sel == SEL_CTL) &&  cmd_kind;
  assign bsr_wr  = wr_any && (sel == SEL_CTL) && !cmd_kind;
endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_wr,
  input  dir_t      new_dir,
  output dir_t      dir
);
  always_ff @(posedge clk) begin
    if (rst)          dir <= DIR_ALL_IN;
    else if (mode_wr) dir <= new_dir;
  end
endmodule

// File: rtl/ppi_out_latch.sv
module ppi_out_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] bit_we,
  input  logic         bit_val,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)     q[i] <= 1'b0;
      else if (ld)        q[i] <= ld_data[i];
      else if (bit_we[i]) q[i] <= bit_val;
    end
  end
endmodule

// File: rtl/ppi_port_ctrl.sv
module ppi_port_ctrl
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PPI_DW-1:0] din,
  output logic [PPI_DW-1:0] dout,
  output logic              dout_en,
  input  logic [PPI_DW-1:0] pa_in,
  output logic [PPI_DW-1:0] pa_out,
  output logic [PPI_DW-1:0] pa_oe,
  input  logic [PPI_DW-1:0] pb_in,
  output logic [PPI_DW-1:0] pb_out,
  output logic [PPI_DW-1:0] pb_oe,
  input  logic [PPI_DW-1:0] pc_in,
  output logic [PPI_DW-1:0] pc_out,
  output logic [PPI_DW-1:0] pc_oe
);
  // named internal events, observed by the bound checker
  logic              wr_a, wr_b, wr_c, mode_wr, bsr_wr, rd_en;
  dir_t              dir;
  logic [PPI_DW-1:0] ctrl_word;
  logic [PPI_DW-1:0] bsr_we;
  logic [PPI_DW-1:0] a_in_mask, b_in_mask, c_in_mask;
  logic [PPI_DW-1:0] unused_din;

  assign unused_din = din;

  ppi_bus_decode u_dec (
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .cmd_kind (din[PPI_DW-1]),
    .wr_a     (wr_a),
    .wr_b     (wr_b),
    .wr_c     (wr_c),
    .mode_wr  (mode_wr),
    .bsr_wr   (bsr_wr),
    .rd_en    (rd_en)
  );

  ppi_ctrl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .mode_wr (mode_wr),
    .new_dir (mode_dirs(din)),
    .dir     (dir)
  );

  assign ctrl_word = ctrl_image(dir);
  assign bsr_we    = bsr_wr ? bit_onehot(din[PPI_SW:1]) : '0;

  ppi_out_latch #(.W(PPI_DW)) u_pa (
    .clk(clk), .rst(rst), .clr(mode_wr), .ld(wr_a), .ld_data(din),
    .bit_we('0), .bit_val(1'b0), .q(pa_out)
  );

  ppi_out_latch #(.W(PPI_DW)) u_pb (
    .clk(clk), .rst(rst), .clr(mode_wr), .ld(wr_b), .ld_data(din),
    .bit_we('0), .bit_val(1'b0), .q(pb_out)
  );

  ppi_out_latch #(.W(PPI_DW)) u_pc (
    .clk(clk), .rst(rst), .clr(mode_wr), .ld(wr_c), .ld_data(din),
    .bit_we(bsr_we), .bit_val(din[0]), .q(pc_out)
  );

  assign a_in_mask = {PPI_DW{dir.a_in}};
  assign b_in_mask = {PPI_DW{dir.b_in}};
  assign c_in_mask = {{PPI_HW{dir.cu_in}}, {PPI_HW{dir.cl_in}}};

  assign pa_oe = ~a_in_mask;
  assign pb_oe = ~b_in_mask;
  assign pc_oe = ~c_in_mask;

  assign dout_en = rd_en;

  always_comb begin
    dout = '0;
    if (rd_en) begin
      unique case (sel_e'(addr))
        SEL_A:   dout = mix_read(pa_out, pa_in, a_in_mask);
        SEL_B:   dout = mix_read(pb_out, pb_in, b_in_mask);
        SEL_C:   dout = mix_read(pc_out, pc_in, c_in_mask);
        SEL_CTL: dout = ctrl_word;
      endcase
    end
  end
endmodule

// File: rtl/ppi_port_ctrl_chk.sv
module ppi_port_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       wr_n,
  input logic       dout_en,
  input logic [7:0] dout,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pc_oe,
  input logic [7:0] ctrl_word,
  input logic       mode_wr,
  input logic       bsr_wr
);
  // R3
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> dout == 8'h00);

  // R2
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n || wr_n) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(ctrl_word)));

  // R6
  mode_clears_latch_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  // R8
  bsr_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    bsr_wr |=> $stable(ctrl_word));

  // R8
  bsr_single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    bsr_wr |=> ($countones(pc_out ^ $past(pc_out)) <= 1));

  // R5
  port_a_oe_whole_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(pa_oe) == 0 || $countones(pa_oe) == 8));

  // R7
  ctrl_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[7] && !ctrl_word[6] && !ctrl_word[5] && !ctrl_word[2]));

  // R5
  pc_half_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(pc_oe[7:4]) % 4 == 0 && $countones(pc_oe[3:0]) % 4 == 0));
endmodule

bind ppi_port_ctrl ppi_port_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .dout_en(dout_en), .dout(dout),
  .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out), .pa_oe(pa_oe), .pc_oe(pc_oe),
  .ctrl_word(ctrl_word), .mode_wr(mode_wr), .bsr_wr(bsr_wr)
);

// File: tb/tb_ppi_port_ctrl.sv
module tb_ppi_port_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       dout_en;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ppi_port_ctrl dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1;
    d = dout; en = dout_en;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  function automatic logic [7:0] pick(input logic [7:0] lat, input logic [7:0] pin, input logic [7:0] inm);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = inm[i] ? pin[i] : lat[i];
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rv, ea, eb, ec, mc, inm_a, inm_b, inm_c;
    logic       en;

    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1", "oe in reset", pa_oe | pb_oe | pc_oe, 8'h00);
    rst = 1'b0;
    check("R1", "pa_out after reset", pa_out, 8'h00);
    check("R1", "pc_out after reset", pc_out | pb_out, 8'h00);
    bus_read(2'd3, rv, en);
    check("R1", "ctrl after reset", rv, 8'h9B);
    check("R3", "dout_en on read", {7'd0, en}, 8'h01);

    // R3: idle bus, chip selected without read
    @(negedge clk);
    cs_n = 1'b0; addr = 2'd3; #1;
    check("R3", "dout_en without rd", {7'd0, dout_en}, 8'h00);
    check("R3", "dout without rd", dout, 8'h00);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    check("R3", "dout without cs", dout, 8'h00);
    rd_n = 1'b1;

    // R4: data writes load latches even with ports as inputs
    bus_write(2'd0, 8'h5A);
    bus_write(2'd1, 8'hC3);
    bus_write(2'd2, 8'h96);
    check("R4", "pa latch", pa_out, 8'h5A);
    check("R4", "pb latch", pb_out, 8'hC3);
    check("R4", "pc latch", pc_out, 8'h96);

    // R2: one strobe missing, no change
    @(negedge clk);
    addr = 2'd0; din = 8'hFF; cs_n = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b0; addr = 2'd3; din = 8'h80;
    @(negedge clk);
    cs_n = 1'b1;
    check("R2", "pa kept, cs high", pa_out, 8'h5A);
    check("R2", "pc kept, wr high", pc_out, 8'h96);
    bus_read(2'd3, rv, en);
    check("R2", "ctrl kept", rv, 8'h9B);

    // sweep all 16 direction combinations
    for (int k = 0; k < 16; k++) begin
      mc = 8'hE4 | (8'(k[3]) << 4) | (8'(k[2]) << 3) | (8'(k[1]) << 1) | 8'(k[0]);
      bus_write(2'd3, mc);
      check("R6", "pa cleared by mode", pa_out, 8'h00);
      check("R6", "pb/pc cleared by mode", pb_out | pc_out, 8'h00);
      inm_a = {8{k[3]}};
      inm_b = {8{k[1]}};
      inm_c = {{4{k[2]}}, {4{k[0]}}};
      check("R5", "pa_oe", pa_oe, ~inm_a);
      check("R5", "pb_oe", pb_oe, ~inm_b);
      check("R5", "pc_oe", pc_oe, ~inm_c);
      bus_read(2'd3, rv, en);
      check("R7", "ctrl readback", rv, 8'h80 | (mc & 8'h1B));
      ea = 8'h3C ^ 8'(k * 17);
      eb = 8'hA1 + 8'(k * 5);
      ec = 8'h69 ^ 8'(k * 29);
      bus_write(2'd0, ea);
      bus_write(2'd1, eb);
      bus_write(2'd2, ec);
      check("R4", "pa_out sweep", pa_out, ea);
      check("R4", "pb_out sweep", pb_out, eb);
      check("R4", "pc_out sweep", pc_out, ec);
      pa_in = ~ea; pb_in = eb ^ 8'h5F; pc_in = ~ec ^ 8'(k);
      bus_read(2'd0, rv, en);
      check("R9", "read A", rv, pick(ea, pa_in, inm_a));
      bus_read(2'd1, rv, en);
      check("R9", "read B", rv, pick(eb, pb_in, inm_b));
      bus_read(2'd2, rv, en);
      check("R9", "read C halves", rv, pick(ec, pc_in, inm_c));
    end

    // R8: bit set/reset over every bit of port C
    bus_write(2'd3, 8'h80);
    ec = 8'h00;
    for (int b = 0; b < 8; b++) begin
      bus_write(2'd3, 8'(b << 1) | 8'h01);
      ec[b] = 1'b1;
      check("R8", "bit set", pc_out, ec);
    end
    for (int b = 7; b >= 0; b -= 2) begin
      bus_write(2'd3, 8'(b << 1) | 8'h70);
      ec[b] = 1'b0;
      check("R8", "bit clear", pc_out, ec);
    end
    check("R8", "pa untouched by bsr", pa_out, 8'h00);
    bus_read(2'd3, rv, en);
    check("R8", "ctrl untouched by bsr", rv, 8'h80);
    bus_read(2'd2, rv, en);
    check("R9", "read C output", rv, ec);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule